// File: doc/BRIEF.md
# SPI Flash Transaction Monitor

This block watches a single-lane SPI link between a host and a serial NOR flash without driving it. Chip select, serial clock and both data lines arrive asynchronously and are brought into the system clock domain by synchronisers. Bits are sampled on the rising serial clock edge (SPI mode 0). The serial clock must run at no more than one quarter of the system clock.

Whole bytes are assembled and the first byte of each transaction is decoded as the opcode. The bytes that follow are interpreted according to that opcode's layout. When chip select is released, one event record is produced. The record carries the opcode, the 24-bit address, the payload byte count, three identification bytes, a misaligned-erase flag and an unknown-opcode flag. Each payload byte is also streamed out on a one-cycle strobe as it is decoded. Dual-line reads are unpacked into ordinary bytes before decoding, so they follow the same layout as a fast read.

Top module: `spi_flash_monitor`

## Requirements
- R1: After chip select falls, the first complete byte is the opcode. When chip select rises, exactly one record is emitted (evValid high for one cycle), provided at least one complete byte was seen. A transaction with no complete byte emits nothing. All decode state restarts with the next transaction.
- R2: For opcodes 0x03, 0x0B, 0xBB, 0x02 and 0x20, the three bytes after the opcode form evAddr, most significant byte first.
- R3: For read 0x03, every byte from the fifth onward is a payload byte taken from MISO. Each one is streamed on dataValid/dataByte, and evCount holds their number.
- R4: For fast read 0x0B, the fifth byte is a dummy that is neither counted nor streamed. Payload bytes start at the sixth byte and are taken from MISO.
- R5: For page program 0x02, every byte from the fifth onward is a payload byte taken from MOSI.
- R6: For dual read 0xBB, each 8-clock window after the opcode yields two bytes. MOSI carries the even bits and MISO the odd bits of a 16-bit word, and the first clock carries bits 15 and 14. The upper byte is decoded before the lower byte. The resulting bytes follow the 0x0B layout: three address bytes, one dummy byte, then payload.
- R7: For sector erase 0x20, evMisaligned is set when the low 12 address bits are not all zero.
- R8: For ID read 0x9F, the MISO bytes of the second, third and fourth bytes go to evIdMfr, evIdType and evIdDev. Later bytes are ignored.
- R9: For 0x90, the fourth byte (MOSI) is a selector. If the selector is 0x00, the fifth-byte reply (MISO) is the manufacturer ID and the sixth is the device ID. Any other selector swaps the two. The values land in evIdMfr and evIdDev.
- R10: For 0xAB, three dummy bytes follow the opcode, and the fifth byte's MISO value is reported in evIdDev.
- R11: An opcode outside the supported set sets evUnknown. All later bytes of that transaction are ignored: address 0, count 0, nothing streamed.
- R12: Status read 0x05 streams MISO bytes from the second byte onward. Status write 0x01 streams MOSI bytes from the second byte onward. Write enable 0x06 has no payload and reports count 0.
- R13: After reset, evValid and dataValid are low and all record fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| spiCsN | input | 1 | Observed chip select, active low |
| spiSck | input | 1 | Observed serial clock |
| spiMosi | input | 1 | Observed host-to-flash line |
| spiMiso | input | 1 | Observed flash-to-host line |
| evValid | output | 1 | One-cycle record strobe |
| evOpcode | output | 8 | Opcode of the finished transaction |
| evAddr | output | 24 | Collected address |
| evCount | output | CNT_W | Payload byte count |
| evIdMfr | output | 8 | Manufacturer ID byte |
| evIdType | output | 8 | Memory type byte |
| evIdDev | output | 8 | Device ID byte |
| evMisaligned | output | 1 | Erase address not on a 4096-byte boundary |
| evUnknown | output | 1 | Opcode not recognised |
| dataValid | output | 1 | One-cycle payload byte strobe |
| dataByte | output | 8 | Payload byte |

## Verification
The embedded assertions check properties on every cycle. A completed byte never coincides with the end of a transaction. The bit counter is empty whenever a transaction ends. A held second dual byte exists only during a dual read. The payload count never falls within a transaction. Records are single-cycle pulses. A misaligned flag appears only on erase records, and an unknown-opcode record never carries an address or count. The per-opcode byte layouts can only be shown by the bench's directed scenarios: the address byte order, the dummy skipping, the choice of line for each payload, the dual-line bit unpacking, the selector-driven ID order, and the suppression of records for partial bytes.

// File: rtl/smon_pkg.sv
package smon_pkg;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FAST  = 8'h0B;
  localparam logic [7:0] OP_DUAL  = 8'hBB;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_ERASE = 8'h20;
  localparam logic [7:0] OP_ID    = 8'h9F;
  localparam logic [7:0] OP_MID   = 8'h90;
  localparam logic [7:0] OP_SRD   = 8'h05;
  localparam logic [7:0] OP_SWR   = 8'h01;
  localparam logic [7:0] OP_WEN   = 8'h06;
  localparam logic [7:0] OP_RES   = 8'hAB;

  typedef enum logic [3:0] {
    CMD_NONE, CMD_READ, CMD_FAST, CMD_DUAL, CMD_PROG, CMD_ERASE,
    CMD_ID, CMD_MID, CMD_SRD, CMD_SWR, CMD_WEN, CMD_RES, CMD_BAD
  } cmdKind_e;

  // Strobes from control to datapath, valid for one cycle each.
  typedef struct packed {
    logic       clear;
    logic       emit;
    logic       opWe;
    logic [7:0] opByte;
    logic       unknownSet;
    logic       addrWe;
    logic [1:0] addrLane;
    logic [7:0] addrByte;
    logic       alignChk;
    logic       idWe;
    logic [1:0] idSlot;
    logic [7:0] idByte;
    logic       dataWe;
    logic [7:0] dataByte;
  } ctlStrobe_t;

  function automatic cmdKind_e classify(input logic [7:0] op);
    case (op)
      OP_READ:  return CMD_READ;
      OP_FAST:  return CMD_FAST;
      OP_DUAL:  return CMD_DUAL;
      OP_PROG:  return CMD_PROG;
      OP_ERASE: return CMD_ERASE;
      OP_ID:    return CMD_ID;
      OP_MID:   return CMD_MID;
      OP_SRD:   return CMD_SRD;
      OP_SWR:   return CMD_SWR;
      OP_WEN:   return CMD_WEN;
      OP_RES:   return CMD_RES;
      default:  return CMD_BAD;
    endcase
  endfunction

  // Even bits from the host line, odd bits from the flash line.
  function automatic logic [15:0] dualMerge(input logic [7:0] evenBits,
                                            input logic [7:0] oddBits);
    logic [15:0] w;
    for (int j = 0; j < 8; j++) begin
      w[2*j]   = evenBits[j];
      w[2*j+1] = oddBits[j];
    end
    return w;
  endfunction

endpackage

// File: rtl/smon_frontend.sv
module smon_frontend #(
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sck,
  input  logic       mosi,
  input  logic       miso,
  output logic       byteValid,
  output logic [7:0] mosiByte,
  output logic [7:0] misoByte,
  output logic       csStart,
  output logic       csEnd
);

  localparam int BIT_W = 3;

  logic [SYNC_N-1:0] csSy, sckSy, moSy, miSy;
  logic csS, sckS, moS, miS;
  logic sckPrev, csPrev;
  logic [BIT_W-1:0] bitCnt;
  logic [6:0] moSh, miSh;
  logic sckRise, csActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csSy  <= '1;
      sckSy <= '0;
      moSy  <= '0;
      miSy  <= '0;
    end else begin
      csSy  <= {csSy[SYNC_N-2:0], csN};
      sckSy <= {sckSy[SYNC_N-2:0], sck};
      moSy  <= {moSy[SYNC_N-2:0], mosi};
      miSy  <= {miSy[SYNC_N-2:0], miso};
    end
  end

  assign csS      = csSy[SYNC_N-1];
  assign sckS     = sckSy[SYNC_N-1];
  assign moS      = moSy[SYNC_N-1];
  assign miS      = miSy[SYNC_N-1];
  assign sckRise  = sckS & ~sckPrev;
  assign csActive = ~csS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckPrev   <= 1'b0;
      csPrev    <= 1'b1;
      bitCnt    <= '0;
      moSh      <= '0;
      miSh      <= '0;
      byteValid <= 1'b0;
      mosiByte  <= '0;
      misoByte  <= '0;
      csStart   <= 1'b0;
      csEnd     <= 1'b0;
    end else begin
      sckPrev   <= sckS;
      csPrev    <= csS;
      byteValid <= 1'b0;
      csStart   <= csPrev & ~csS;
      csEnd     <= ~csPrev & csS;
      if (!csActive) begin
        bitCnt <= '0;
      end else if (sckRise) begin
        moSh   <= {moSh[5:0], moS};
        miSh   <= {miSh[5:0], miS};
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == '1) begin
          byteValid <= 1'b1;
          mosiByte  <= {moSh, moS};
          misoByte  <= {miSh, miS};
        end
      end
    end
  end

  // R1: a finished byte never lands on the end of a transaction
  assert_byte_not_at_end_R1: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> !csEnd);

  // R1: partial bits are dropped when chip select rises
  assert_bits_cleared_at_end_R1: assert property (@(posedge clk) disable iff (!rstN)
    csEnd |-> bitCnt == '0);

endmodule

// File: rtl/smon_control.sv
module smon_control
  import smon_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic [7:0] mosiByte,
  input  logic [7:0] misoByte,
  input  logic       csStart,
  input  logic       csEnd,
  output ctlStrobe_t st
);

  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [IDX_W-1:0] idx;
  cmdKind_e kind;
  logic selZero;
  logic pendValid;
  logic [7:0] pendByte;
  logic dualMode;
  logic [15:0] dualWord;
  logic lbValid;
  logic [7:0] lbMosi, lbMiso;
  logic frameEdge;

  assign frameEdge = csStart | csEnd;
  assign dualMode  = (kind == CMD_DUAL) && (idx != '0);
  assign dualWord  = dualMerge(mosiByte, misoByte);
  assign lbValid   = (byteValid | pendValid) & ~frameEdge;

  // One logical byte per cycle: a held dual byte, an unpacked dual byte,
  // or a plain pair of line bytes.
  always_comb begin
    if (pendValid) begin
      lbMosi = pendByte;
      lbMiso = pendByte;
    end else if (dualMode) begin
      lbMosi = dualWord[15:8];
      lbMiso = dualWord[15:8];
    end else begin
      lbMosi = mosiByte;
      lbMiso = misoByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx       <= '0;
      kind      <= CMD_NONE;
      selZero   <= 1'b0;
      pendValid <= 1'b0;
      pendByte  <= '0;
    end else if (frameEdge) begin
      idx       <= '0;
      kind      <= CMD_NONE;
      selZero   <= 1'b0;
      pendValid <= 1'b0;
    end else begin
      pendValid <= byteValid & dualMode & ~pendValid;
      if (byteValid && dualMode) pendByte <= dualWord[7:0];
      if (lbValid) begin
        if (idx != IDX_MAX) idx <= idx + 1'b1;
        if (idx == '0) kind <= classify(lbMosi);
        if (kind == CMD_MID && idx == IDX_W'(3)) selZero <= (lbMosi == 8'h00);
      end
    end
  end

  always_comb begin
    st       = '0;
    st.clear = csStart;
    st.emit  = csEnd && (idx != '0);
    if (lbValid) begin
      if (idx == '0) begin
        st.opWe       = 1'b1;
        st.opByte     = lbMosi;
        st.unknownSet = (classify(lbMosi) == CMD_BAD);
      end else begin
        case (kind)
          CMD_READ, CMD_FAST, CMD_DUAL, CMD_PROG, CMD_ERASE: begin
            if (idx <= IDX_W'(3)) begin
              st.addrWe   = 1'b1;
              st.addrLane = 2'(idx - 1'b1);
              st.addrByte = lbMosi;
              st.alignChk = (kind == CMD_ERASE) && (idx == IDX_W'(3));
            end
            if ((kind == CMD_READ && idx >= IDX_W'(4)) ||
                ((kind == CMD_FAST || kind == CMD_DUAL) && idx >= IDX_W'(5))) begin
              st.dataWe   = 1'b1;
              st.dataByte = lbMiso;
            end
            if (kind == CMD_PROG && idx >= IDX_W'(4)) begin
              st.dataWe   = 1'b1;
              st.dataByte = lbMosi;
            end
          end
          CMD_ID: begin
            if (idx <= IDX_W'(3)) begin
              st.idWe   = 1'b1;
              st.idSlot = 2'(idx - 1'b1);
              st.idByte = lbMiso;
            end
          end
          CMD_MID: begin
            if (idx == IDX_W'(4) || idx == IDX_W'(5)) begin
              st.idWe   = 1'b1;
              st.idByte = lbMiso;
              st.idSlot = ((idx == IDX_W'(4)) == selZero) ? 2'd0 : 2'd2;
            end
          end
          CMD_RES: begin
            if (idx == IDX_W'(4)) begin
              st.idWe   = 1'b1;
              st.idSlot = 2'd2;
              st.idByte = lbMiso;
            end
          end
          CMD_SRD: begin
            st.dataWe   = 1'b1;
            st.dataByte = lbMiso;
          end
          CMD_SWR: begin
            st.dataWe   = 1'b1;
            st.dataByte = lbMosi;
          end
          default: ;
        endcase
      end
    end
  end

  // R6: a held second byte exists only inside a dual read
  assert_pend_only_dual_R6: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |-> kind == CMD_DUAL);

  // R11: an unrecognised opcode produces no further field writes
  assert_unknown_silent_R11: assert property (@(posedge clk) disable iff (!rstN)
    (kind == CMD_BAD) |-> !(st.addrWe || st.idWe || st.dataWe));

endmodule

// File: rtl/smon_datapath.sv
module smon_datapath
  import smon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       st,
  output logic             evValid,
  output logic [7:0]       evOpcode,
  output logic [23:0]      evAddr,
  output logic [CNT_W-1:0] evCount,
  output logic [7:0]       evIdMfr,
  output logic [7:0]       evIdType,
  output logic [7:0]       evIdDev,
  output logic             evMisaligned,
  output logic             evUnknown,
  output logic             dataValid,
  output logic [7:0]       dataByte
);

  localparam int ID_N = 3;

  logic [7:0]       opQ;
  logic [23:0]      addrQ;
  logic [CNT_W-1:0] cntQ;
  logic [7:0]       idQ [ID_N];
  logic             misQ, unkQ;
  logic             restart;

  assign restart = st.emit | st.clear;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ  <= '0;
      addrQ <= '0;
      cntQ <= '0;
      misQ <= 1'b0;
      unkQ <= 1'b0;
    end else if (restart) begin
      opQ  <= '0;
      addrQ <= '0;
      cntQ <= '0;
      misQ <= 1'b0;
      unkQ <= 1'b0;
    end else begin
      if (st.opWe) opQ <= st.opByte;
      if (st.unknownSet) unkQ <= 1'b1;
      if (st.addrWe) addrQ[(2 - st.addrLane) * 8 +: 8] <= st.addrByte;
      if (st.alignChk) misQ <= ({addrQ[11:8], st.addrByte} != 12'd0);
      if (st.dataWe && cntQ != '1) cntQ <= cntQ + 1'b1;
    end
  end

  for (genvar g = 0; g < ID_N; g++) begin : gIdSlot
    always_ff @(posedge clk) begin
      if (!rstN || restart) idQ[g] <= '0;
      else if (st.idWe && st.idSlot == 2'(g)) idQ[g] <= st.idByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evValid      <= 1'b0;
      evOpcode     <= '0;
      evAddr       <= '0;
      evCount      <= '0;
      evIdMfr      <= '0;
      evIdType     <= '0;
      evIdDev      <= '0;
      evMisaligned <= 1'b0;
      evUnknown    <= 1'b0;
      dataValid    <= 1'b0;
      dataByte     <= '0;
    end else begin
      evValid   <= st.emit;
      dataValid <= st.dataWe;
      if (st.dataWe) dataByte <= st.dataByte;
      if (st.emit) begin
        evOpcode     <= opQ;
        evAddr       <= addrQ;
        evCount      <= cntQ;
        evIdMfr      <= idQ[0];
        evIdType     <= idQ[1];
        evIdDev      <= idQ[2];
        evMisaligned <= misQ;
        evUnknown    <= unkQ;
      end
    end
  end

  // R1: each record is a single-cycle pulse
  assert_single_record_R1: assert property (@(posedge clk) disable iff (!rstN)
    evValid |=> !evValid);

  // R3: the payload count only grows inside a transaction
  assert_count_monotonic_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(restart) |-> cntQ >= $past(cntQ));

  // R7: only erase records may carry the alignment flag
  assert_misalign_erase_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evMisaligned) |-> evOpcode == OP_ERASE);

  // R11: an unknown-opcode record carries no address or count
  assert_unknown_empty_R11: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evUnknown) |-> (evCount == '0 && evAddr == '0));

endmodule

// File: rtl/spi_flash_monitor.sv
module spi_flash_monitor
  import smon_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 4,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             spiCsN,
  input  logic             spiSck,
  input  logic             spiMosi,
  input  logic             spiMiso,
  output logic             evValid,
  output logic [7:0]       evOpcode,
  output logic [23:0]      evAddr,
  output logic [CNT_W-1:0] evCount,
  output logic [7:0]       evIdMfr,
  output logic [7:0]       evIdType,
  output logic [7:0]       evIdDev,
  output logic             evMisaligned,
  output logic             evUnknown,
  output logic             dataValid,
  output logic [7:0]       dataByte
);

  logic       byteValid, csStart, csEnd;
  logic [7:0] mosiByte, misoByte;
  ctlStrobe_t st;

  smon_frontend #(.SYNC_N(SYNC_N)) uFront (
    .clk(clk), .rstN(rstN), .csN(spiCsN), .sck(spiSck), .mosi(spiMosi),
    .miso(spiMiso), .byteValid(byteValid), .mosiByte(mosiByte),
    .misoByte(misoByte), .csStart(csStart), .csEnd(csEnd)
  );

  smon_control #(.IDX_W(IDX_W)) uCtl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .mosiByte(mosiByte),
    .misoByte(misoByte), .csStart(csStart), .csEnd(csEnd), .st(st)
  );

  smon_datapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .st(st), .evValid(evValid), .evOpcode(evOpcode),
    .evAddr(evAddr), .evCount(evCount), .evIdMfr(evIdMfr),
    .evIdType(evIdType), .evIdDev(evIdDev), .evMisaligned(evMisaligned),
    .evUnknown(evUnknown), .dataValid(dataValid), .dataByte(dataByte)
  );

endmodule

// File: tb/tb_spi_flash_monitor.sv
module tb_spi_flash_monitor;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b0, mosi = 1'b0, miso = 1'b0;
  logic evValid, evMisaligned, evUnknown, dataValid;
  logic [7:0] evOpcode, evIdMfr, evIdType, evIdDev, dataByte;
  logic [23:0] evAddr;
  logic [15:0] evCount;

  int checks = 0, errors = 0;
  int recCnt = 0, recBefore = 0, dataN = 0;
  logic [7:0] dataBuf [64];
  logic [7:0] rOp, rMfr, rType, rDev;
  logic [23:0] rAddr;
  logic [15:0] rCnt;
  logic rMis, rUnk;

  always #2.5 clk = ~clk;

  spi_flash_monitor dut (
    .clk(clk), .rstN(rstN), .spiCsN(csN), .spiSck(sck), .spiMosi(mosi),
    .spiMiso(miso), .evValid(evValid), .evOpcode(evOpcode), .evAddr(evAddr),
    .evCount(evCount), .evIdMfr(evIdMfr), .evIdType(evIdType),
    .evIdDev(evIdDev), .evMisaligned(evMisaligned), .evUnknown(evUnknown),
    .dataValid(dataValid), .dataByte(dataByte)
  );

  always @(negedge clk) begin
    if (dataValid && dataN < 64) begin
      dataBuf[dataN] = dataByte;
      dataN = dataN + 1;
    end
    if (evValid) begin
      recCnt = recCnt + 1;
      rOp = evOpcode; rAddr = evAddr; rCnt = evCount; rMfr = evIdMfr;
      rType = evIdType; rDev = evIdDev; rMis = evMisaligned; rUnk = evUnknown;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shiftBits(input logic [7:0] mo, input logic [7:0] mi, input int nbits);
    for (int b = 7; b > 7 - nbits; b--) begin
      mosi = mo[b]; miso = mi[b];
      waitClk(4); sck = 1'b1;
      waitClk(4); sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] mo, input logic [7:0] mi);
    shiftBits(mo, mi, 8);
  endtask

  // Dual window: clock k carries word bit 15-2k on MISO and 14-2k on MOSI
  task automatic dualXfer(input logic [7:0] b1, input logic [7:0] b2);
    logic [15:0] w;
    w = {b1, b2};
    for (int k = 0; k < 8; k++) begin
      miso = w[15-2*k]; mosi = w[14-2*k];
      waitClk(4); sck = 1'b1;
      waitClk(4); sck = 1'b0;
    end
  endtask

  task automatic beginTx();
    dataN = 0;
    recBefore = recCnt;
    csN = 1'b0;
    waitClk(4);
  endtask

  task automatic endTx(input string req, input int expRecs);
    waitClk(6);
    csN = 1'b1;
    waitClk(30);
    chk(req, recCnt - recBefore, expRecs);
  endtask

  task automatic testReset();
    chk("R13 evValid", evValid, 0);
    chk("R13 dataValid", dataValid, 0);
    chk("R13 evOpcode", evOpcode, 0);
    chk("R13 evAddr", evAddr, 0);
    chk("R13 evCount", evCount, 0);
  endtask

  task automatic testRead();
    beginTx();
    xfer(8'h03, 8'hFF); xfer(8'h12, 8'hFF); xfer(8'h34, 8'hFF); xfer(8'h56, 8'hFF);
    xfer(8'h00, 8'hA5); xfer(8'h00, 8'h3C); xfer(8'h00, 8'h7E);
    endTx("R1 one record", 1);
    chk("R1 opcode", rOp, 8'h03);
    chk("R2 address", rAddr, 24'h123456);
    chk("R3 count", rCnt, 3);
    chk("R3 stream n", dataN, 3);
    chk("R3 stream", {dataBuf[0], dataBuf[1], dataBuf[2]}, 24'hA53C7E);
    chk("R3 ids zero", {rMfr, rType, rDev}, 0);
  endtask

  task automatic testFast();
    beginTx();
    xfer(8'h0B, 8'h00); xfer(8'h00, 8'h00); xfer(8'h10, 8'h00); xfer(8'h00, 8'h00);
    xfer(8'h00, 8'hFF); xfer(8'h00, 8'h11); xfer(8'h00, 8'h22);
    endTx("R4 record", 1);
    chk("R4 address", rAddr, 24'h001000);
    chk("R4 count skips dummy", rCnt, 2);
    chk("R4 stream", {dataBuf[0], dataBuf[1]}, 16'h1122);
  endtask

  task automatic testProg();
    beginTx();
    xfer(8'h02, 8'hFF); xfer(8'hAB, 8'hFF); xfer(8'hCD, 8'hFF); xfer(8'hEF, 8'hFF);
    for (int i = 1; i <= 4; i++) xfer(8'(i), 8'hFF);
    endTx("R5 record", 1);
    chk("R5 address", rAddr, 24'hABCDEF);
    chk("R5 count", rCnt, 4);
    chk("R5 stream from MOSI",
        {dataBuf[0], dataBuf[1], dataBuf[2], dataBuf[3]}, 32'h01020304);
  endtask

  task automatic testDual();
    beginTx();
    xfer(8'hBB, 8'h00);
    dualXfer(8'h01, 8'h23); dualXfer(8'h45, 8'h99);
    dualXfer(8'hDE, 8'hAD); dualXfer(8'hBE, 8'hEF);
    endTx("R6 record", 1);
    chk("R6 opcode", rOp, 8'hBB);
    chk("R6 address", rAddr, 24'h012345);
    chk("R6 count", rCnt, 4);
    chk("R6 stream",
        {dataBuf[0], dataBuf[1], dataBuf[2], dataBuf[3]}, 32'hDEADBEEF);
  endtask

  task automatic testErase();
    beginTx();
    xfer(8'h20, 8'hFF); xfer(8'h02, 8'hFF); xfer(8'h30, 8'hFF); xfer(8'h00, 8'hFF);
    endTx("R7 record", 1);
    chk("R7 aligned flag", rMis, 0);
    chk("R7 aligned addr", rAddr, 24'h023000);
    beginTx();
    xfer(8'h20, 8'hFF); xfer(8'h02, 8'hFF); xfer(8'h30, 8'hFF); xfer(8'h10, 8'hFF);
    endTx("R7 record", 1);
    chk("R7 misaligned flag", rMis, 1);
  endtask

  task automatic testId();
    beginTx();
    xfer(8'h9F, 8'hFF); xfer(8'h00, 8'hEF); xfer(8'h00, 8'h40);
    xfer(8'h00, 8'h18); xfer(8'h00, 8'h77);
    endTx("R8 record", 1);
    chk("R8 ids", {rMfr, rType, rDev}, 24'hEF4018);
    chk("R8 extra ignored", rCnt, 0);
  endtask

  task automatic testMid();
    beginTx();
    xfer(8'h90, 8'hFF); xfer(8'h00, 8'hFF); xfer(8'h00, 8'hFF); xfer(8'h00, 8'hFF);
    xfer(8'h00, 8'hC2); xfer(8'h00, 8'h17);
    endTx("R9 record", 1);
    chk("R9 selector 0 order", {rMfr, rDev}, 16'hC217);
    beginTx();
    xfer(8'h90, 8'hFF); xfer(8'h00, 8'hFF); xfer(8'h00, 8'hFF); xfer(8'h01, 8'hFF);
    xfer(8'h00, 8'h17); xfer(8'h00, 8'hC2);
    endTx("R9 record", 1);
    chk("R9 selector 1 order", {rMfr, rDev}, 16'hC217);
  endtask

  task automatic testRes();
    beginTx();
    xfer(8'hAB, 8'hFF); xfer(8'h00, 8'h11); xfer(8'h00, 8'h22); xfer(8'h00, 8'h33);
    xfer(8'h00, 8'h5A);
    endTx("R10 record", 1);
    chk("R10 device id", rDev, 8'h5A);
    chk("R10 mfr untouched", rMfr, 8'h00);
  endtask

  task automatic testUnknown();
    beginTx();
    xfer(8'h77, 8'hFF); xfer(8'h12, 8'h34); xfer(8'h56, 8'h78); xfer(8'h9A, 8'hBC);
    xfer(8'hDE, 8'hF0);
    endTx("R11 record", 1);
    chk("R11 flag", rUnk, 1);
    chk("R11 addr", rAddr, 0);
    chk("R11 count", rCnt, 0);
    chk("R11 no stream", dataN, 0);
  endtask

  task automatic testStatus();
    beginTx();
    xfer(8'h05, 8'hFF); xfer(8'h00, 8'h03); xfer(8'h00, 8'h00);
    endTx("R12 record", 1);
    chk("R12 read count", rCnt, 2);
    chk("R12 read stream", {dataBuf[0], dataBuf[1]}, 16'h0300);
    beginTx();
    xfer(8'h01, 8'hFF); xfer(8'h02, 8'hFF);
    endTx("R12 record", 1);
    chk("R12 write stream", dataBuf[0], 8'h02);
    chk("R12 write count", rCnt, 1);
    beginTx();
    xfer(8'h06, 8'hFF);
    endTx("R12 record", 1);
    chk("R12 enable opcode", rOp, 8'h06);
    chk("R12 enable count", rCnt, 0);
    chk("R12 enable not unknown", rUnk, 0);
  endtask

  task automatic testPartial();
    beginTx();
    shiftBits(8'h03, 8'hFF, 5);
    endTx("R1 partial no record", 0);
    beginTx();
    endTx("R1 empty no record", 0);
  endtask

  task automatic finish();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    waitClk(6);
    testReset();
    rstN = 1'b1;
    waitClk(4);
    testRead();
    testFast();
    testProg();
    testDual();
    testErase();
    testId();
    testMid();
    testRes();
    testUnknown();
    testStatus();
    testPartial();
    finish();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all actual hung expected done");
    finish();
  end

endmodule